// File: doc/BRIEF.md
# Target Termination Classifier

This block watches the handshake lines of a shared parallel bus with active-low control signals (transaction frame, initiator ready, target ready, device select and stop). It names the way each data phase ends: a normal transfer, a disconnect that still moves data, a disconnect that moves none, a retry, or a target abort. Each result appears as a one-hot code that lasts one clock. A separate strobe marks the clock after the bus goes back to idle.

The block also holds the target-side drivers for the target-ready and stop pins. The local target logic asks for each pin with an active-high request while it owns the bus. The driver keeps a target-ready assertion in place until the initiator completes the data phase. When ownership ends, both pins are driven high for one clock before their output enables drop, which hands the lines to the external pull-ups. The block has no data stream, so there is no valid/ready handshake: every pin is plain control or status and is sampled on each rising clock edge.

Top module: `tgt_term_unit`

## Requirements
- R1: An edge that sees initiator ready, target ready and device select asserted and stop deasserted produces the normal code, bit 0 of `term_code` (5'b00001), in the following cycle.
- R2: An edge that sees stop, target ready, device select and initiator ready all asserted produces the disconnect-with-data code, bit 1 (5'b00010).
- R3: An edge that sees stop, device select and initiator ready asserted with target ready deasserted, after a data phase of the same transaction has completed, produces the disconnect-without-data code, bit 2 (5'b00100).
- R4: The same stop condition as in R3, seen before any data phase of the transaction has completed, produces the retry code, bit 3 (5'b01000).
- R5: An edge that sees stop and initiator ready asserted with device select deasserted produces the target-abort code, bit 4 (5'b10000).
- R6: Only edges with initiator ready asserted are classified. Wait states and address cycles give a code of zero, and at most one code bit is ever set.
- R7: After a stop-based code (bits 1 to 4), no further code appears until the bus has been sampled idle (frame and initiator ready both deasserted).
- R8: The record of completed data phases clears when the bus is idle, so a stop without data on the first phase of the next transaction is a retry.
- R9: `term_eot` is high for exactly the one cycle after the first edge that samples the bus idle following a busy edge.
- R10: While `own_sel` is high, `trdy_drv_n` follows `own_trdy_req` one cycle later. Once it is low, it stays low until an edge that samples initiator ready asserted.
- R11: While `own_sel` is high, `stop_drv_n` is low in the cycle after an edge that samples `own_stop_req` high.
- R12: When `own_sel` drops, both driven pins are high with both enables on for exactly one cycle. After that, both enables are off. `trdy_oe` and `stop_oe` are always equal.
- R13: A synchronous reset (`rst_n` low) gives a zero code, a low `term_eot`, both enables off and both driven pins high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_frame_n | input | 1 | Observed transaction frame, active low |
| bus_irdy_n | input | 1 | Observed initiator ready, active low |
| bus_trdy_n | input | 1 | Observed target ready, active low |
| bus_devsel_n | input | 1 | Observed device select, active low |
| bus_stop_n | input | 1 | Observed stop, active low |
| own_sel | input | 1 | Local target owns the current transaction |
| own_trdy_req | input | 1 | Local request to assert target ready |
| own_stop_req | input | 1 | Local request to assert stop |
| term_code | output | 5 | One-hot termination code, one cycle per event |
| term_eot | output | 1 | End-of-transaction strobe |
| trdy_drv_n | output | 1 | Driven value of the target-ready pin |
| trdy_oe | output | 1 | Output enable of the target-ready pin |
| stop_drv_n | output | 1 | Driven value of the stop pin |
| stop_oe | output | 1 | Output enable of the stop pin |

## Verification
The bench checks the retry versus disconnect-without-data split in both directions. A retry follows a transaction that moved data, and a disconnect without data follows a normal phase in the same transaction. A block that did not track completed phases, or that never cleared that record at idle, would report the wrong one of the two codes. Wait states and stop held across several cycles are driven to catch a design that classifies without initiator ready or that repeats a stop code. On the driver side, the bench drops the target-ready request before the initiator is ready, then checks the one-cycle high-drive release, which catches a driver that lets go too early or never lets go.

// File: rtl/tgt_term_pkg.sv
package tgt_term_pkg;

  localparam int CODE_W     = 5;
  localparam int IDX_NORMAL = 0;
  localparam int IDX_DWD    = 1;
  localparam int IDX_DND    = 2;
  localparam int IDX_RETRY  = 3;
  localparam int IDX_ABORT  = 4;

  typedef enum logic [1:0] {
    PIN_IDLE    = 2'd0,
    PIN_OWN     = 2'd1,
    PIN_RELEASE = 2'd2
  } pin_state_e;

  // Bus lines converted to active-high form.
  typedef struct packed {
    logic frame;
    logic irdy;
    logic trdy;
    logic devsel;
    logic stop;
  } bus_sample_t;

endpackage

// File: rtl/tgt_term_classifier.sv
module tgt_term_classifier
  import tgt_term_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bus_sample_t       bus,
  output logic [CODE_W-1:0] code,
  output logic              eot
);

  logic xfer_q;     // a data phase of this transaction has completed
  logic stopped_q;  // a stop-based code has already been reported
  logic busy_q;
  logic busy;
  logic phase_eval;
  logic done_xfer;
  logic [CODE_W-1:0] code_d;

  assign busy       = bus.frame | bus.irdy;
  assign phase_eval = bus.irdy & ~stopped_q;
  assign done_xfer  = bus.irdy & bus.trdy & bus.devsel;

  always_comb begin
    code_d = '0;
    if (phase_eval) begin
      if (bus.stop && !bus.devsel) begin
        code_d[IDX_ABORT] = 1'b1;
      end else if (bus.stop && bus.trdy) begin
        code_d[IDX_DWD] = 1'b1;
      end else if (bus.stop) begin
        if (xfer_q) code_d[IDX_DND]   = 1'b1;
        else        code_d[IDX_RETRY] = 1'b1;
      end else if (bus.trdy && bus.devsel) begin
        code_d[IDX_NORMAL] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code      <= '0;
      eot       <= 1'b0;
      busy_q    <= 1'b0;
      xfer_q    <= 1'b0;
      stopped_q <= 1'b0;
    end else begin
      code      <= code_d;
      eot       <= busy_q & ~busy;
      busy_q    <= busy;
      xfer_q    <= busy ? (xfer_q | done_xfer) : 1'b0;
      stopped_q <= busy ? (stopped_q | (phase_eval & bus.stop)) : 1'b0;
    end
  end

endmodule

// File: rtl/tgt_pin_seq.sv
module tgt_pin_seq
  import tgt_term_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic own,
  input  logic want_trdy,
  input  logic want_stop,
  input  logic irdy_seen,
  output logic trdy_n,
  output logic stop_n,
  output logic pins_oe
);

  pin_state_e state_q, state_d;
  logic trdy_q, trdy_d;
  logic stop_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PIN_IDLE:    if (own) state_d = PIN_OWN;
      PIN_OWN:     if (!own) state_d = PIN_RELEASE;
      PIN_RELEASE: state_d = own ? PIN_OWN : PIN_IDLE;
      default:     state_d = PIN_IDLE;
    endcase
  end

  // Target ready is held until the initiator completes the phase.
  always_comb begin
    if (!own)                    trdy_d = 1'b0;
    else if (trdy_q && !irdy_seen) trdy_d = 1'b1;
    else                         trdy_d = want_trdy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PIN_IDLE;
      trdy_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      trdy_q  <= trdy_d;
      stop_q  <= own & want_stop;
    end
  end

  assign pins_oe = (state_q != PIN_IDLE);
  assign trdy_n  = ~((state_q == PIN_OWN) & trdy_q);
  assign stop_n  = ~((state_q == PIN_OWN) & stop_q);

endmodule

// File: rtl/tgt_term_unit.sv
module tgt_term_unit
  import tgt_term_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_frame_n,
  input  logic              bus_irdy_n,
  input  logic              bus_trdy_n,
  input  logic              bus_devsel_n,
  input  logic              bus_stop_n,
  input  logic              own_sel,
  input  logic              own_trdy_req,
  input  logic              own_stop_req,
  output logic [CODE_W-1:0] term_code,
  output logic              term_eot,
  output logic              trdy_drv_n,
  output logic              trdy_oe,
  output logic              stop_drv_n,
  output logic              stop_oe
);

  bus_sample_t bus_s;
  logic        oe_w;

  assign bus_s.frame  = ~bus_frame_n;
  assign bus_s.irdy   = ~bus_irdy_n;
  assign bus_s.trdy   = ~bus_trdy_n;
  assign bus_s.devsel = ~bus_devsel_n;
  assign bus_s.stop   = ~bus_stop_n;

  tgt_term_classifier cls_i (
    .clk   (clk),
    .rst_n (rst_n),
    .bus   (bus_s),
    .code  (term_code),
    .eot   (term_eot)
  );

  tgt_pin_seq pins_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .own       (own_sel),
    .want_trdy (own_trdy_req),
    .want_stop (own_stop_req),
    .irdy_seen (bus_s.irdy),
    .trdy_n    (trdy_drv_n),
    .stop_n    (stop_drv_n),
    .pins_oe   (oe_w)
  );

  assign trdy_oe = oe_w;
  assign stop_oe = oe_w;

endmodule

// File: rtl/tgt_term_unit_chk.sv
module tgt_term_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_irdy_n,
  input logic       own_sel,
  input logic [4:0] term_code,
  input logic       term_eot,
  input logic       trdy_drv_n,
  input logic       trdy_oe,
  input logic       stop_drv_n,
  input logic       stop_oe
);

  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(term_code));

  a_r7_single_stop_code: assert property (@(posedge clk) disable iff (!rst_n)
    (|term_code[4:1]) |=> !(|term_code[4:1]));

  a_r9_eot_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    term_eot |=> !term_eot);

  a_r10_trdy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_drv_n && bus_irdy_n && own_sel) |=> !trdy_drv_n);

  a_r12_release_high: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_oe && (!trdy_drv_n || !stop_drv_n) && !own_sel)
      |=> (trdy_oe && stop_oe && trdy_drv_n && stop_drv_n));

  a_r12_release_off: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_oe && !own_sel && !$past(own_sel)) |=> !trdy_oe);

  a_r12_oe_pair: assert property (@(posedge clk) disable iff (!rst_n)
    trdy_oe == stop_oe);

endmodule

bind tgt_term_unit tgt_term_unit_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_irdy_n (bus_irdy_n),
  .own_sel    (own_sel),
  .term_code  (term_code),
  .term_eot   (term_eot),
  .trdy_drv_n (trdy_drv_n),
  .trdy_oe    (trdy_oe),
  .stop_drv_n (stop_drv_n),
  .stop_oe    (stop_oe)
);

// File: tb/tgt_term_unit_tb_top.sv
module tgt_term_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] C_NONE = 5'b00000;
  localparam logic [4:0] C_NORM = 5'b00001;
  localparam logic [4:0] C_DWD  = 5'b00010;
  localparam logic [4:0] C_DND  = 5'b00100;
  localparam logic [4:0] C_RTRY = 5'b01000;
  localparam logic [4:0] C_ABRT = 5'b10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_frame_n = 1'b1, bus_irdy_n = 1'b1, bus_trdy_n = 1'b1;
  logic bus_devsel_n = 1'b1, bus_stop_n = 1'b1;
  logic own_sel = 1'b0, own_trdy_req = 1'b0, own_stop_req = 1'b0;
  logic [4:0] term_code;
  logic term_eot, trdy_drv_n, trdy_oe, stop_drv_n, stop_oe;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [4:0] code;
    logic       eot;
    string      tag;
  } exp_item_t;

  exp_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tgt_term_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n), .bus_trdy_n(bus_trdy_n),
    .bus_devsel_n(bus_devsel_n), .bus_stop_n(bus_stop_n),
    .own_sel(own_sel), .own_trdy_req(own_trdy_req), .own_stop_req(own_stop_req),
    .term_code(term_code), .term_eot(term_eot),
    .trdy_drv_n(trdy_drv_n), .trdy_oe(trdy_oe),
    .stop_drv_n(stop_drv_n), .stop_oe(stop_oe)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Driver: one bus cycle, arguments are "asserted" flags; expectation queued.
  task automatic cyc(input logic f, input logic i, input logic t, input logic d,
                     input logic s, input logic [4:0] ec, input logic ee,
                     input string tag);
    exp_item_t it;
    @(negedge clk);
    bus_frame_n  = ~f;
    bus_irdy_n   = ~i;
    bus_trdy_n   = ~t;
    bus_devsel_n = ~d;
    bus_stop_n   = ~s;
    it.code = ec;
    it.eot  = ee;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares after the edge that applied the queued cycle.
  always begin
    @(posedge clk);
    #1;
    if (sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (term_code !== it.code) begin
        errors++;
        $display("FAIL %s code actual=%b expected=%b", it.tag, term_code, it.code);
      end
      checks++;
      if (term_eot !== it.eot) begin
        errors++;
        $display("FAIL %s eot actual=%b expected=%b", it.tag, term_eot, it.eot);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R13: reset state
    check_bit("R13 code zero", |term_code, 1'b0);
    check_bit("R13 eot low", term_eot, 1'b0);
    check_bit("R13 trdy_oe off", trdy_oe, 1'b0);
    check_bit("R13 stop_oe off", stop_oe, 1'b0);
    check_bit("R13 trdy high", trdy_drv_n, 1'b1);
    check_bit("R13 stop high", stop_drv_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: two normal phases, then idle with end strobe (R9)
    cyc(1,0,0,0,0, C_NONE, 0, "R6 address cycle");
    cyc(1,1,1,1,0, C_NORM, 0, "R1 phase 1");
    cyc(0,1,1,1,0, C_NORM, 0, "R1 last phase");
    cyc(0,0,0,0,0, C_NONE, 1, "R9 eot pulse");
    cyc(0,0,0,0,0, C_NONE, 0, "R9 eot single");

    // R4 + R8: data moved last transaction, first-phase stop is retry
    cyc(1,0,0,0,0, C_NONE, 0, "R6 address cycle");
    cyc(1,1,0,1,1, C_RTRY, 0, "R4 R8 retry");
    cyc(0,1,0,1,1, C_NONE, 0, "R7 stop held no repeat");
    cyc(0,0,0,0,0, C_NONE, 1, "R9 eot after retry");

    // R3: disconnect without data after a transfer
    cyc(1,0,0,0,0, C_NONE, 0, "R6 address cycle");
    cyc(1,1,1,1,0, C_NORM, 0, "R1 before disconnect");
    cyc(1,1,0,1,1, C_DND,  0, "R3 disconnect no data");
    cyc(0,1,0,1,1, C_NONE, 0, "R7 stop held no repeat");
    cyc(0,0,0,0,0, C_NONE, 1, "R9 eot");

    // R6: wait states give no code
    cyc(1,0,0,0,0, C_NONE, 0, "R6 address cycle");
    cyc(1,0,1,1,0, C_NONE, 0, "R6 trdy without irdy");
    cyc(1,1,0,1,0, C_NONE, 0, "R6 target wait state");
    cyc(0,1,1,1,0, C_NORM, 0, "R1 after waits");
    cyc(0,0,0,0,0, C_NONE, 1, "R9 eot");

    // R2: disconnect with data
    cyc(1,0,0,0,0, C_NONE, 0, "R6 address cycle");
    cyc(1,1,1,1,1, C_DWD,  0, "R2 disconnect with data");
    cyc(0,1,0,1,1, C_NONE, 0, "R7 no second code");
    cyc(0,0,0,0,0, C_NONE, 1, "R9 eot");

    // R8: flag from previous data cleared, stop is retry again
    cyc(1,0,0,0,0, C_NONE, 0, "R6 address cycle");
    cyc(1,1,0,1,1, C_RTRY, 0, "R8 retry after idle");
    cyc(0,0,0,0,0, C_NONE, 1, "R9 eot");

    // R5: target abort
    cyc(1,0,0,0,0, C_NONE, 0, "R6 address cycle");
    cyc(1,1,0,0,1, C_ABRT, 0, "R5 target abort");
    cyc(0,1,0,0,1, C_NONE, 0, "R7 abort held no repeat");
    cyc(0,0,0,0,0, C_NONE, 1, "R9 eot");
    cyc(0,0,0,0,0, C_NONE, 0, "R9 idle quiet");
    wait (sb_q.size() == 0);
    repeat (2) @(posedge clk);

    // R10: target-ready driver
    @(negedge clk);
    own_sel = 1'b1; own_trdy_req = 1'b1;
    @(posedge clk); #1;
    check_bit("R10 trdy asserted", trdy_drv_n, 1'b0);
    check_bit("R12 enable on while owned", trdy_oe, 1'b1);
    check_bit("R11 stop idle high", stop_drv_n, 1'b1);
    @(negedge clk);
    own_trdy_req = 1'b0;
    @(posedge clk); #1;
    check_bit("R10 trdy held without irdy", trdy_drv_n, 1'b0);
    @(negedge clk);
    bus_irdy_n = 1'b0;
    @(posedge clk); #1;
    check_bit("R10 trdy released after phase", trdy_drv_n, 1'b1);
    // R11: stop driver
    @(negedge clk);
    bus_irdy_n = 1'b1; own_stop_req = 1'b1;
    @(posedge clk); #1;
    check_bit("R11 stop asserted", stop_drv_n, 1'b0);
    // R12: release sequence
    @(negedge clk);
    own_sel = 1'b0; own_stop_req = 1'b0;
    @(posedge clk); #1;
    check_bit("R12 release trdy_oe on", trdy_oe, 1'b1);
    check_bit("R12 release stop_oe on", stop_oe, 1'b1);
    check_bit("R12 release stop high", stop_drv_n, 1'b1);
    check_bit("R12 release trdy high", trdy_drv_n, 1'b1);
    @(posedge clk); #1;
    check_bit("R12 trdy_oe off", trdy_oe, 1'b0);
    check_bit("R12 stop_oe off", stop_oe, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule